// File: doc/BRIEF.md
# GPIO Bank with Edge-Detect Interrupts

This block is one bank of up to 32 general-purpose pins, controlled through a small synchronous register bus. Software never rewrites the output latch as a whole. It drives pins high through a set register and low through a clear register, where each 1 in the written word acts on one pin and each 0 leaves its pin alone. A direction register gates the output enables. A per-pin parameter mask reverses the meaning of a direction bit for pins whose pad treats 1 as input.

Pin inputs are brought into the clock domain by a two-flop synchronizer. A rising-enable mask and a falling-enable mask choose, per pin, which transitions of the synchronized level are latched into a sticky status register. Software clears a status bit only by writing a 1 to it. A single interrupt line follows the OR of all status bits.

Word addresses: 0 level (read-only), 1 direction, 2 set (reads return the output latch), 3 clear (reads return the output latch), 4 rising enable, 5 falling enable, 6 status (write ones to clear), 7 reads 0.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, pin_out and pin_oe are all 0, irq is 0, the rising-enable, falling-enable and status registers read 0, and the direction register reads back INVERT_MASK, so that every pin is an input.
- R2: Writing to address 2 sets each output latch bit whose written bit is 1. Bits written as 0 keep their value. The change is visible on pin_out after the write clock edge, and the latch changes on no other write.
- R3: Writing to address 3 clears each output latch bit whose written bit is 1. Bits written as 0 keep their value.
- R4: A read of address 0 returns pin_in as it stood two clock edges earlier, one bit per pin.
- R5: pin_oe[i] equals direction bit i, inverted when INVERT_MASK[i] is 1.
- R6: A 0-to-1 change of a synchronized pin sets its status bit when its rising-enable bit is 1. A 1-to-0 change sets it when its falling-enable bit is 1. With both enables set, either change sets it. The status bit is set on the third clock edge after the pin input changes.
- R7: A status bit stays set until a write to address 6 carries a 1 in its position. Writing 0 bits has no effect, and writing all ones clears every bit.
- R8: With both enable bits of a pin at 0, transitions on that pin latch nothing, while status bits already set stay set.
- R9: irq is the OR of the status bits, registered one clock after the status register changes.
- R10: When an enabled edge and a clearing write hit the same status bit in the same clock, the bit stays set.
- R11: Register bit positions at and above NUM_PINS read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | NUM_PINS | Pad input levels |
| pin_out | output | NUM_PINS | Output latch |
| pin_oe | output | NUM_PINS | Output enables |
| irq | output | 1 | Combined edge interrupt |

## Verification
The assertions check on every cycle that status bits never clear without a clearing write and never appear without an event, that a new event survives a simultaneous clear, that irq follows the status OR one clock later, and that the output latch moves only on a set or clear write. Only the bench scenarios can show the things that depend on the chosen stimulus. These are the three-edge latency from pin to status, the selection of transitions by each enable mask, the readback of masked positions above NUM_PINS, and the inverted direction pins in operation.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_LEVEL  = 3'd0,
        SEL_DIR    = 3'd1,
        SEL_SET    = 3'd2,
        SEL_CLR    = 3'd3,
        SEL_RISE   = 3'd4,
        SEL_FALL   = 3'd5,
        SEL_STATUS = 3'd6,
        SEL_NONE   = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 32,
    parameter logic [31:0] INVERT_MASK = 32'h0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  reg_sel_e            sel,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] out_q,
    output logic [NUM_PINS-1:0] rise_q,
    output logic [NUM_PINS-1:0] fall_q
);
    typedef struct packed {
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] out;
        logic [NUM_PINS-1:0] rise;
        logic [NUM_PINS-1:0] fall;
    } ctrl_t;

    localparam logic [NUM_PINS-1:0] DIR_RST = INVERT_MASK[NUM_PINS-1:0];

    ctrl_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            unique case (sel)
                SEL_DIR:  state_d.dir  = wdata;
                SEL_SET:  state_d.out  = state_q.out | wdata;
                SEL_CLR:  state_d.out  = state_q.out & ~wdata;
                SEL_RISE: state_d.rise = wdata;
                SEL_FALL: state_d.fall = wdata;
                default:  state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.dir  <= DIR_RST;
            state_q.out  <= '0;
            state_q.rise <= '0;
            state_q.fall <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign dir_q  = state_q.dir;
    assign out_q  = state_q.out;
    assign rise_q = state_q.rise;
    assign fall_q = state_q.fall;

    // R2
    out_only_on_setclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (sel == SEL_SET || sel == SEL_CLR)) |=> $stable(out_q));
endmodule

// File: rtl/gpio_edge_latch.sv
module gpio_edge_latch #(
    parameter int unsigned NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] level,
    input  logic [NUM_PINS-1:0] rise_en,
    input  logic [NUM_PINS-1:0] fall_en,
    input  logic                clr_wr,
    input  logic [NUM_PINS-1:0] clr_mask,
    output logic [NUM_PINS-1:0] status,
    output logic                irq
);
    typedef struct packed {
        logic [NUM_PINS-1:0] prev;
        logic [NUM_PINS-1:0] status;
        logic                irq;
    } edge_t;

    edge_t st_d, st_q;
    logic [NUM_PINS-1:0] event_vec;
    logic [NUM_PINS-1:0] wipe;

    always_comb begin
        event_vec   = (level & ~st_q.prev & rise_en) | (~level & st_q.prev & fall_en);
        wipe        = clr_wr ? clr_mask : '0;
        st_d.prev   = level;
        st_d.status = (st_q.status & ~wipe) | event_vec;
        st_d.irq    = |st_q.status;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.status;
    assign irq    = st_q.irq;

    // R7
    sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(status) & ~$past(wipe)) == ($past(status) & ~$past(wipe))));
    // R8
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(event_vec)) == '0));
    // R10
    edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (event_vec != '0) |=> ((status & $past(event_vec)) == $past(event_vec)));
    // R9
    irq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status != '0) |=> irq);
    // R9
    irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |=> !irq);
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 32,
    parameter logic [31:0] INVERT_MASK = 32'h0,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    reg_sel_e            sel;
    logic [NUM_PINS-1:0] wdata_pins;
    logic [NUM_PINS-1:0] level;
    logic [NUM_PINS-1:0] dir_q, out_q, rise_q, fall_q, status;
    logic [NUM_PINS-1:0] rd_pins;
    logic                clr_wr;

    assign sel        = reg_sel_e'(bus_addr);
    assign wdata_pins = bus_wdata[NUM_PINS-1:0];
    assign clr_wr     = bus_wr && (sel == SEL_STATUS);

    gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(level)
    );

    gpio_ctrl_regs #(.NUM_PINS(NUM_PINS), .INVERT_MASK(INVERT_MASK)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .sel(sel), .wdata(wdata_pins),
        .dir_q(dir_q), .out_q(out_q), .rise_q(rise_q), .fall_q(fall_q)
    );

    gpio_edge_latch #(.NUM_PINS(NUM_PINS)) u_edge (
        .clk(clk), .rst_n(rst_n), .level(level), .rise_en(rise_q), .fall_en(fall_q),
        .clr_wr(clr_wr), .clr_mask(wdata_pins), .status(status), .irq(irq)
    );

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_oe
            if (INVERT_MASK[i]) begin : g_inv
                assign pin_oe[i] = ~dir_q[i];
            end else begin : g_pass
                assign pin_oe[i] = dir_q[i];
            end
        end
    endgenerate

    assign pin_out = out_q;

    always_comb begin
        unique case (sel)
            SEL_LEVEL:          rd_pins = level;
            SEL_DIR:            rd_pins = dir_q;
            SEL_SET, SEL_CLR:   rd_pins = out_q;
            SEL_RISE:           rd_pins = rise_q;
            SEL_FALL:           rd_pins = fall_q;
            SEL_STATUS:         rd_pins = status;
            default:            rd_pins = '0;
        endcase
        bus_rdata = '0;
        bus_rdata[NUM_PINS-1:0] = rd_pins;
    end
endmodule

// File: tb/gpio_edge_bank_test.sv
module gpio_edge_bank_test;
    localparam int unsigned NP  = 20;
    localparam logic [31:0] INV = 32'h0000_0005;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_edge_bank #(.NUM_PINS(NP), .INVERT_MASK(INV)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    typedef struct packed {
        logic        is_wr;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [31:0] exp_rd;
        logic [19:0] exp_out;
        logic [19:0] exp_oe;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd1, 32'h0,          32'h5,     20'h0,   20'h0 },   // R1
        '{1'b1, 3'd2, 32'h000A5,      32'h0,     20'hA5,  20'h0 },   // R2
        '{1'b0, 3'd2, 32'h0,          32'hA5,    20'hA5,  20'h0 },   // R2
        '{1'b1, 3'd2, 32'h00100,      32'h0,     20'h1A5, 20'h0 },   // R2
        '{1'b1, 3'd3, 32'h00021,      32'h0,     20'h184, 20'h0 },   // R3
        '{1'b1, 3'd1, 32'h000F0,      32'h0,     20'h184, 20'hF5 },  // R5
        '{1'b0, 3'd1, 32'h0,          32'hF0,    20'h184, 20'hF5 },  // R5
        '{1'b1, 3'd1, 32'h00005,      32'h0,     20'h184, 20'h0 },   // R5
        '{1'b1, 3'd2, 32'hFFF00000,   32'h0,     20'h184, 20'h0 },   // R11
        '{1'b0, 3'd3, 32'h0,          32'h184,   20'h184, 20'h0 },   // R11
        '{1'b1, 3'd4, 32'hFFFFFFFF,   32'h0,     20'h184, 20'h0 },   // R11
        '{1'b0, 3'd4, 32'h0,          32'hFFFFF, 20'h184, 20'h0 },   // R11
        '{1'b0, 3'd7, 32'h0,          32'h0,     20'h184, 20'h0 }    // R11
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R1 reset state
        check("R1 pin_out", 32'(pin_out), 32'h0);
        check("R1 pin_oe",  32'(pin_oe),  32'h0);
        check("R1 irq",     32'(irq),     32'h0);
        rd(3'd6, r); check("R1 status", r, 32'h0);
        rd(3'd4, r); check("R1 rise",   r, 32'h0);
        rd(3'd5, r); check("R1 fall",   r, 32'h0);

        for (int v = 0; v < NV; v++) begin
            if (VECS[v].is_wr) wr(VECS[v].addr, VECS[v].data);
            else begin
                rd(VECS[v].addr, r);
                check("R1/R2/R3/R5/R11 table read", r, VECS[v].exp_rd);
            end
            check("R2/R3 table pin_out", 32'(pin_out), 32'(VECS[v].exp_out));
            check("R5 table pin_oe",     32'(pin_oe),  32'(VECS[v].exp_oe));
        end
        wr(3'd4, 32'h0);

        // R4 level sync latency
        @(negedge clk);
        pin_in = 20'hA5A5A;
        rd(3'd0, r); check("R4 level before edges", r, 32'h0);
        wait_n(1);
        rd(3'd0, r); check("R4 level after one edge", r, 32'h0);
        wait_n(1);
        rd(3'd0, r); check("R4 level after two edges", r, 32'hA5A5A);
        pin_in = '0;
        wait_n(4);
        wr(3'd6, 32'hFFFFFFFF);
        wait_n(1);

        // R6 edge selection
        wr(3'd4, 32'hA);
        wr(3'd5, 32'hC);
        @(negedge clk);
        pin_in = 20'hE;
        wait_n(2);
        rd(3'd6, r); check("R6 status not yet set", r, 32'h0);
        wait_n(1);
        rd(3'd6, r); check("R6 rising events", r, 32'hA);
        check("R9 irq lags status", 32'(irq), 32'h0);
        wait_n(1);
        check("R9 irq asserted", 32'(irq), 32'h1);
        @(negedge clk);
        pin_in = '0;
        wait_n(4);
        rd(3'd6, r); check("R6 falling events added", r, 32'hE);

        // R7 write-one-to-clear
        wr(3'd6, 32'h0);
        rd(3'd6, r); check("R7 zero write ignored", r, 32'hE);
        wr(3'd6, 32'h2);
        rd(3'd6, r); check("R7 single bit cleared", r, 32'hC);

        // R8 disabled enables
        wr(3'd4, 32'h0);
        wr(3'd5, 32'h0);
        @(negedge clk);
        pin_in = 20'hFF;
        wait_n(4);
        pin_in = '0;
        wait_n(4);
        rd(3'd6, r); check("R8 no new events, pending kept", r, 32'hC);

        // R10 edge wins over same-cycle clear
        wr(3'd4, 32'h8);
        @(negedge clk);
        pin_in = 20'h8;
        @(negedge clk);
        wr(3'd6, 32'h8);
        rd(3'd6, r); check("R10 edge beats clear", r, 32'hC);
        wr(3'd6, 32'h8);
        rd(3'd6, r); check("R10 later clear works", r, 32'h4);

        // R7 clear all, R9 irq falls one clock later
        wr(3'd6, 32'hFFFFFFFF);
        rd(3'd6, r); check("R7 clear all", r, 32'h0);
        check("R9 irq still high", 32'(irq), 32'h1);
        wait_n(1);
        check("R9 irq dropped", 32'(irq), 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule